// File: doc/BRIEF.md
# Interleaved Block-Refill Memory Model

This block is a cycle-accurate main-memory model that serves cache refills one whole block at a time. Storage is split into four banks, each one word wide. All four banks share a single one-word data bus that runs at bus rate. A request carries a block address and a read/write flag. The address transfer takes one cycle and reaches every bank at once. The banks then run their accesses side by side, and the bus moves the four words one per cycle. A 4-word block therefore costs 1 + 15 + 4 = 20 bus cycles. If the banks worked one after another, the same block would need four full access latencies.

A word address is formed as `{block, bank}`: the low two bits pick the bank, and the remaining bits pick the row inside every bank. A separate fill port lets a bench preload any word directly while the model is idle. During a write burst, the requester presents one word per transfer cycle on the write-data input. The per-word strobe tells the requester when each word is taken.

Top module: `ilv_refill_mem`

## Requirements
- R1: While rst_ni is low, busy_o, word_vld_o and done_o are 0 and rdata_o is all zeros.
- R2: A request (req_i high while busy_o is low) is accepted in that cycle. busy_o is then high for the next ACCESS_LAT + NUM_BANKS cycles (19 by default) and low again in the cycle after.
- R3: For a read accepted in cycle c, word k of the block appears on rdata_o in cycle c + ACCESS_LAT + 1 + k (c+16 to c+19 by default). Word k is the word at word address {block, k}, held in bank k.
- R4: Each burst raises word_vld_o for exactly NUM_BANKS consecutive cycles, in bank order 0 upward. done_o is high only together with the last of these strobes.
- R5: A whole burst, from the address cycle to the done cycle inclusive, spans 1 + ACCESS_LAT + NUM_BANKS cycles (20 by default). A request held high is accepted again in the cycle right after done_o.
- R6: A request presented while busy_o is high is ignored. It neither alters the burst in progress nor changes any stored word.
- R7: For a write accepted in cycle c, the value on wdata_i in cycle c + ACCESS_LAT + 1 + k is stored at word address {block, k}. word_vld_o marks each such cycle.
- R8: When fill_en_i is high while busy_o is low, fill_data_i is stored at word address fill_addr_i. Its low two bits select the bank and its upper bits select the row. A fill presented while busy_o is high is ignored.
- R9: rdata_o is all zeros in every cycle without a read word on the bus, including the strobes of a write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Block request |
| req_we_i | input | 1 | 1 = block write, 0 = block read |
| req_blk_i | input | ROW_W | Block address (row in every bank) |
| wdata_i | input | WORD_W | Write word, sampled on each write strobe |
| fill_en_i | input | 1 | Direct preload enable |
| fill_addr_i | input | ROW_W+2 | Preload word address {row, bank} |
| fill_data_i | input | WORD_W | Preload word |
| busy_o | output | 1 | Burst in progress; requests are refused |
| word_vld_o | output | 1 | One word moves on the bus this cycle |
| rdata_o | output | WORD_W | Read word |
| done_o | output | 1 | Last word of the burst |

## Verification
The bench builds the block with ROW_W = 4, which gives 16 rows per bank and a 64-word space. The bench preloads every word of that space through the fill port, so any read compares against known data. ACCESS_LAT stays at 15 and NUM_BANKS at 4, so each check exercises the full 20-cycle burst timing and its exact strobe positions. With the space this small, a stray write caused by an ignored request or fill would corrupt a word that a later burst reads back and compares.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_XFER   = 2'd2
  } phase_e;
endpackage

// File: rtl/ilv_burst_seq.sv
module ilv_burst_seq
  import ilv_mem_pkg::*;
#(
  parameter int ACCESS_LAT = 15,
  parameter int NUM_BANKS  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  output phase_e                       phase_o,
  output logic [$clog2(NUM_BANKS)-1:0] beat_o,
  output logic                         last_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_MAX = (ACCESS_LAT > NUM_BANKS) ? ACCESS_LAT : NUM_BANKS;
  localparam int CNT_W  = $clog2(CNT_MAX) + 1;
  localparam logic [CNT_W-1:0] ACC_END  = CNT_W'(ACCESS_LAT - 1);
  localparam logic [CNT_W-1:0] XFER_END = CNT_W'(NUM_BANKS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_ACCESS;
          cnt_q   <= '0;
        end
        PH_ACCESS: if (cnt_q == ACC_END) begin
          phase_q <= PH_XFER;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PH_XFER: if (cnt_q == XFER_END) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign beat_o  = cnt_q[BANK_W-1:0];
  assign last_o  = (phase_q == PH_XFER) && (cnt_q == XFER_END);
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  wrow_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ROW_W-1:0]  rrow_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ROW_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wrow_i] <= wdata_i;
  end

  // access latency is modelled by the sequencer, the array itself reads through
  assign rdata_o = mem_q[rrow_i];
endmodule

// File: rtl/ilv_refill_mem.sv
module ilv_refill_mem
  import ilv_mem_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ROW_W      = 8,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 15
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    req_i,
  input  logic                                    req_we_i,
  input  logic [ROW_W-1:0]                        req_blk_i,
  input  logic [WORD_W-1:0]                       wdata_i,
  input  logic                                    fill_en_i,
  input  logic [ROW_W+$clog2(NUM_BANKS)-1:0]      fill_addr_i,
  input  logic [WORD_W-1:0]                       fill_data_i,
  output logic                                    busy_o,
  output logic                                    word_vld_o,
  output logic [WORD_W-1:0]                       rdata_o,
  output logic                                    done_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  phase_e             phase;
  logic [BANK_W-1:0]  beat;
  logic               last;
  logic               idle, xfer, start;
  logic [ROW_W-1:0]   blk_q;
  logic               we_q;
  logic [WORD_W-1:0]  bank_rdata [NUM_BANKS];

  assign idle  = (phase == PH_IDLE);
  assign xfer  = (phase == PH_XFER);
  assign start = req_i && idle;

  ilv_burst_seq #(
    .ACCESS_LAT (ACCESS_LAT),
    .NUM_BANKS  (NUM_BANKS)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .phase_o (phase),
    .beat_o  (beat),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      we_q  <= 1'b0;
    end else if (start) begin
      blk_q <= req_blk_i;
      we_q  <= req_we_i;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              we_b;
    logic [ROW_W-1:0]  wrow_b;
    logic [WORD_W-1:0] wdata_b;

    // burst writes own the bank during transfer; fills only land when idle
    assign we_b = (idle && fill_en_i && (fill_addr_i[BANK_W-1:0] == BANK_W'(b)))
               || (xfer && we_q && (beat == BANK_W'(b)));
    assign wrow_b  = xfer ? blk_q : fill_addr_i[ROW_W+BANK_W-1:BANK_W];
    assign wdata_b = xfer ? wdata_i : fill_data_i;

    ilv_bank #(
      .WORD_W (WORD_W),
      .ROW_W  (ROW_W)
    ) u_bank (
      .clk_i   (clk_i),
      .we_i    (we_b),
      .wrow_i  (wrow_b),
      .wdata_i (wdata_b),
      .rrow_i  (blk_q),
      .rdata_o (bank_rdata[b])
    );
  end

  assign busy_o     = !idle;
  assign word_vld_o = xfer;
  assign done_o     = last;
  assign rdata_o    = (xfer && !we_q) ? bank_rdata[beat] : '0;
endmodule

// File: rtl/ilv_refill_mem_chk.sv
module ilv_refill_mem_chk #(
  parameter int WORD_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              word_vld_o,
  input logic              done_o,
  input logic [WORD_W-1:0] rdata_o
);
  localparam int BUSY_CYC = ACCESS_LAT + NUM_BANKS;

  logic [15:0] busy_run_q;
  logic [15:0] vld_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_run_q <= '0;
      vld_run_q  <= '0;
    end else begin
      busy_run_q <= busy_o ? busy_run_q + 1'b1 : '0;
      vld_run_q  <= word_vld_o ? vld_run_q + 1'b1 : '0;
    end
  end

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);

  a_r2_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run_q == 16'(BUSY_CYC)));

  a_r4_vld_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(word_vld_o) |-> (vld_run_q == 16'(NUM_BANKS)));

  a_r4_done_with_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> word_vld_o);

  a_r5_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !word_vld_o);

  a_r6_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r9_rdata_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> (rdata_o == '0));
endmodule

bind ilv_refill_mem ilv_refill_mem_chk #(
  .WORD_W     (WORD_W),
  .NUM_BANKS  (NUM_BANKS),
  .ACCESS_LAT (ACCESS_LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .busy_o     (busy_o),
  .word_vld_o (word_vld_o),
  .done_o     (done_o),
  .rdata_o    (rdata_o)
);

// File: tb/ilv_refill_mem_bench.sv
module ilv_refill_mem_bench;
  localparam int WW = 32, RW = 4, NB = 4, AL = 15, BW = 2;
  localparam int NWORDS = NB << RW;
  localparam int BUSY = AL + NB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [RW-1:0] req_blk = '0;
  logic [WW-1:0] wdata = '0;
  logic fill_en = 1'b0;
  logic [RW+BW-1:0] fill_addr = '0;
  logic [WW-1:0] fill_data = '0;
  logic busy, vld, done;
  logic [WW-1:0] rdata;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ilv_refill_mem #(.WORD_W(WW), .ROW_W(RW), .NUM_BANKS(NB), .ACCESS_LAT(AL)) u_ilv_refill_mem (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we), .req_blk_i(req_blk),
    .wdata_i(wdata), .fill_en_i(fill_en), .fill_addr_i(fill_addr), .fill_data_i(fill_data),
    .busy_o(busy), .word_vld_o(vld), .rdata_o(rdata), .done_o(done));

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(input int w);
    return {8'hC3, 16'(w * 37 + 5), 8'(w)};
  endfunction

  // behavioural reference: flat word array and a cycle counter since acceptance
  logic [WW-1:0] ref_mem [NWORDS];
  int m_t;
  logic [RW-1:0] m_blk;
  logic m_we;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t <= 0; m_blk <= '0; m_we <= 1'b0;
    end else if (m_t == 0) begin
      if (fill_en) ref_mem[fill_addr] <= fill_data;
      if (req) begin m_t <= 1; m_blk <= req_blk; m_we <= req_we; end
    end else begin
      if (m_t > AL && m_we) ref_mem[{m_blk, BW'(m_t - AL - 1)}] <= wdata;
      m_t <= (m_t == BUSY) ? 0 : m_t + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", {31'b0, busy}, {31'b0, m_t != 0});
      check("R4 word_vld", {31'b0, vld}, {31'b0, m_t > AL});
      check("R5 done", {31'b0, done}, {31'b0, m_t == BUSY});
      if (m_t > AL && !m_we) check("R3 rdata", rdata, ref_mem[{m_blk, BW'(m_t - AL - 1)}]);
      else check("R9 rdata quiet", rdata, '0);
    end
  end

  task automatic burst(input logic [RW-1:0] blk, input logic we, input logic [WW-1:0] wd [NB],
                       input logic noisy, output logic [WW-1:0] rd [NB],
                       output int first_vld, output int nvld, output int done_at);
    int cyc = 0;
    first_vld = -1; nvld = 0; done_at = -1;
    @(negedge clk);
    req = 1'b1; req_blk = blk; req_we = we;
    forever begin
      @(negedge clk);
      cyc++;
      req = 1'b0; fill_en = 1'b0;
      if (vld) begin
        if (nvld == 0) first_vld = cyc;
        rd[nvld] = rdata;
        if (we) wdata = wd[nvld];
        nvld++;
      end
      if (done || cyc > 40) begin done_at = cyc; break; end
      if (noisy) begin
        req = 1'b1; req_we = 1'b1; req_blk = 4'd9;
        fill_en = 1'b1; fill_addr = '0; fill_data = 32'hDEAD_BEEF;
      end
    end
    req = 1'b0; req_we = 1'b0; fill_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [WW-1:0] wd [NB];
    logic [WW-1:0] rd [NB];
    int fv, nv, da, lows;
    foreach (wd[i]) wd[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy}, '0);
    check("R1 vld in reset", {31'b0, vld}, '0);
    check("R1 done in reset", {31'b0, done}, '0);
    check("R1 rdata in reset", rdata, '0);
    rst_n = 1'b1;

    // R8: preload every word through the fill port
    for (int w = 0; w < NWORDS; w++) begin
      @(negedge clk);
      fill_en = 1'b1; fill_addr = (RW+BW)'(w); fill_data = pat(w);
    end
    @(negedge clk);
    fill_en = 1'b0;

    // R3 R4 R5: plain read timing and data
    burst(4'd3, 1'b0, wd, 1'b0, rd, fv, nv, da);
    check("R3 first word cycle", fv, AL + 1);
    check("R4 strobe count", nv, NB);
    check("R5 done cycle", da, BUSY);
    for (int k = 0; k < NB; k++) check("R3 block 3 word", rd[k], pat(12 + k));

    // R6 R8: requests and fills during a burst are ignored
    burst(4'd5, 1'b0, wd, 1'b1, rd, fv, nv, da);
    check("R6 timing under noise", da, BUSY);
    for (int k = 0; k < NB; k++) check("R6 block 5 word", rd[k], pat(20 + k));
    burst(4'd0, 1'b0, wd, 1'b0, rd, fv, nv, da);
    check("R8 busy fill ignored", rd[0], pat(0));
    burst(4'd9, 1'b0, wd, 1'b0, rd, fv, nv, da);
    for (int k = 0; k < NB; k++) check("R6 block 9 untouched", rd[k], pat(36 + k));

    // R7: block write then read back
    for (int k = 0; k < NB; k++) wd[k] = 32'h1234_0000 + 32'(k * 17);
    burst(4'd2, 1'b1, wd, 1'b0, rd, fv, nv, da);
    check("R7 write strobes", nv, NB);
    burst(4'd2, 1'b0, wd, 1'b0, rd, fv, nv, da);
    for (int k = 0; k < NB; k++) check("R7 written word", rd[k], wd[k]);

    // R8: idle fill lands in bank = low bits, row = upper bits
    @(negedge clk);
    fill_en = 1'b1; fill_addr = 6'd7; fill_data = 32'h0BAD_F00D;
    @(negedge clk);
    fill_en = 1'b0;
    burst(4'd1, 1'b0, wd, 1'b0, rd, fv, nv, da);
    check("R8 fill bank 3 row 1", rd[3], 32'h0BAD_F00D);
    check("R8 neighbour kept", rd[2], pat(6));

    // R5: request held high is re-accepted right after done
    @(negedge clk);
    req = 1'b1; req_blk = 4'd4; req_we = 1'b0;
    lows = 0;
    for (int c = 1; c < 40; c++) begin
      @(negedge clk);
      if (!busy) lows++;
    end
    check("R5 single idle cycle between bursts", lows, 1);
    req = 1'b0;
    repeat (BUSY + 3) @(negedge clk);
    check("R2 idle after bursts", {31'b0, busy}, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule